// File: doc/BRIEF.md
# Addressable Bit Latch with One-Hot Demultiplexer

This block keeps a small bank of single-bit storage cells (eight by default). A binary address picks one cell and one data bit is written into it. Two active-low controls, a write enable and a clear, are sampled on every rising clock edge. Together they choose one of four modes: write the addressed cell, hold every cell, decode the data bit onto the addressed output only, or clear the whole bank.

The output vector shows the cell registers directly, one bit per cell. Every change becomes visible one clock edge after the inputs that caused it. In decode mode the bank acts as a one-hot demultiplexer: the addressed bit carries the data and every other bit is forced low. The cell contents are undefined after power-on until clear mode has been applied once. The clear mode therefore also serves as the block's reset.

Top module: `addressable_latch_demux`

## Requirements
- R1: With enableN high and clearN low at a rising edge (clear mode), every output bit is 0 after that edge, whatever the address and data are.
- R2: With enableN low and clearN high (write mode), the cell selected by the address takes the data bit at the edge, and every other cell keeps its value.
- R3: With enableN high and clearN high (hold mode), no cell changes at the edge, whatever the address and data are.
- R4: With enableN low and clearN low (decode mode), after the edge the addressed output equals the data bit and all other outputs are 0.
- R5: The address is plain binary with bit 0 as its least significant bit: address value k selects output bit k.
- R6: After decode mode, a switch to hold mode keeps the decoded pattern. All non-addressed cells stay cleared and the addressed cell keeps the last data bit.
- R7: Controls, address and data act only at the rising clock edge. An input change between edges leaves the outputs unchanged until the next edge, and the value stored is the data present at that edge.
- R8: Between two consecutive write-mode cycles, the address may change in at most one bit. Wider address changes belong in hold mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all modes take effect on its rising edge |
| dataIn | input | 1 | Data bit written or decoded |
| addrIn | input | ADDR_W (3) | Binary cell address |
| enableN | input | 1 | Active-low write/decode enable |
| clearN | input | 1 | Active-low clear/decode select |
| cellsOut | output | 2**ADDR_W (8) | Cell contents, bit k is cell k |

## Verification
On every cycle after the first clear, the assertions check the effect of each of the four modes on the cell vector. Hold leaves the vector unchanged, clear zeroes it, decode yields a single data-qualified one-hot bit, and write touches only the addressed cell. They also flag a multi-bit address step between write cycles. Only the bench's scenarios can show the binary mapping of every address, which needs a sweep of all eight cells. The same holds for the sequence in which a decoded pattern survives a later hold, and for the absence of any output change between clock edges.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;
  // Strobes from the mode decoder to the cell bank
  typedef struct packed {
    logic writeSel;   // addressed cell loads dataIn
    logic clearRest;  // non-addressed cells are zeroed
    logic clearAll;   // every cell is zeroed
  } cellStrobe_t;
endpackage

// File: rtl/addr_latch_ctrl.sv
module addr_latch_ctrl
  import addr_latch_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              enableN,
  input  logic              clearN,
  input  logic [ADDR_W-1:0] addrIn,
  output cellStrobe_t       strobe
);
  logic writeMode;
  logic armed;

  assign writeMode        = !enableN && clearN;
  assign strobe.writeSel  = !enableN;
  assign strobe.clearRest = !enableN && !clearN;
  assign strobe.clearAll  = enableN && !clearN;

  // Checking starts once the bank has seen a clear
  always_ff @(posedge clk) begin
    armed <= armed | strobe.clearAll;
  end

  // R8: address moves by at most one bit between back-to-back write cycles
  assert_addr_step_R8: assert property (@(posedge clk) disable iff (!armed)
    (writeMode && $past(writeMode)) |-> ($countones(addrIn ^ $past(addrIn)) <= 1));
endmodule

// File: rtl/addr_latch_bank.sv
module addr_latch_bank
  import addr_latch_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic                   clk,
  input  cellStrobe_t            strobe,
  input  logic [ADDR_W-1:0]      addrIn,
  input  logic                   dataIn,
  output logic [(1<<ADDR_W)-1:0] cells
);
  localparam int CELLS = 1 << ADDR_W;

  logic [CELLS-1:0] hitVec;
  logic             armed;

  always_comb begin
    hitVec = '0;
    hitVec[addrIn] = 1'b1;
  end

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    logic cellQ;
    always_ff @(posedge clk) begin
      if (strobe.clearAll)
        cellQ <= 1'b0;
      else if (strobe.writeSel && hitVec[i])
        cellQ <= dataIn;
      else if (strobe.clearRest)
        cellQ <= 1'b0;
    end
    assign cells[i] = cellQ;
  end

  always_ff @(posedge clk) begin
    armed <= armed | strobe.clearAll;
  end

  // R1: clear empties the bank
  assert_clear_all_R1: assert property (@(posedge clk) disable iff (!armed)
    strobe.clearAll |=> (cells == '0));

  // R2: write changes only the addressed cell
  assert_write_one_R2: assert property (@(posedge clk) disable iff (!armed)
    (strobe.writeSel && !strobe.clearRest) |=>
      ((cells[$past(addrIn)] == $past(dataIn)) &&
       ((cells & ~(CELLS'(1) << $past(addrIn))) ==
        ($past(cells) & ~(CELLS'(1) << $past(addrIn))))));

  // R3: hold keeps every cell
  assert_hold_stable_R3: assert property (@(posedge clk) disable iff (!armed)
    (!strobe.writeSel && !strobe.clearAll) |=> $stable(cells));

  // R4: decode gives a data-qualified one-hot pattern
  assert_decode_onehot_R4: assert property (@(posedge clk) disable iff (!armed)
    strobe.clearRest |=>
      ($onehot0(cells) && (cells == (CELLS'($past(dataIn)) << $past(addrIn)))));
endmodule

// File: rtl/addressable_latch_demux.sv
module addressable_latch_demux
  import addr_latch_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic                   clk,
  input  logic                   dataIn,
  input  logic [ADDR_W-1:0]      addrIn,
  input  logic                   enableN,
  input  logic                   clearN,
  output logic [(1<<ADDR_W)-1:0] cellsOut
);
  cellStrobe_t strobe;

  addr_latch_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .enableN (enableN),
    .clearN  (clearN),
    .addrIn  (addrIn),
    .strobe  (strobe)
  );

  addr_latch_bank #(.ADDR_W(ADDR_W)) u_bank (
    .clk    (clk),
    .strobe (strobe),
    .addrIn (addrIn),
    .dataIn (dataIn),
    .cells  (cellsOut)
  );
endmodule

// File: tb/addressable_latch_demux_tb.sv
module addressable_latch_demux_tb;
  logic       clk = 1'b0;
  logic       dataIn = 1'b0;
  logic [2:0] addrIn = 3'd0;
  logic       enableN = 1'b1;
  logic       clearN = 1'b1;
  logic [7:0] cellsOut;

  int applied = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  addressable_latch_demux u_dut (
    .clk(clk), .dataIn(dataIn), .addrIn(addrIn),
    .enableN(enableN), .clearN(clearN), .cellsOut(cellsOut)
  );

  // {enableN, clearN, addr, data, expected outputs after the edge}
  localparam int NV = 21;
  localparam logic [13:0] VEC [NV] = '{
    {1'b1,1'b0,3'd5,1'b1,8'h00},
    {1'b0,1'b1,3'd0,1'b1,8'h01},
    {1'b0,1'b1,3'd1,1'b1,8'h03},
    {1'b0,1'b1,3'd3,1'b1,8'h0B},
    {1'b0,1'b1,3'd3,1'b0,8'h03},
    {1'b1,1'b1,3'd6,1'b1,8'h03},
    {1'b0,1'b1,3'd6,1'b1,8'h43},
    {1'b0,1'b1,3'd7,1'b1,8'hC3},
    {1'b1,1'b1,3'd2,1'b1,8'hC3},
    {1'b1,1'b1,3'd5,1'b0,8'hC3},
    {1'b0,1'b0,3'd5,1'b1,8'h20},
    {1'b1,1'b1,3'd5,1'b0,8'h20},
    {1'b0,1'b0,3'd2,1'b0,8'h00},
    {1'b0,1'b0,3'd2,1'b1,8'h04},
    {1'b1,1'b0,3'd2,1'b1,8'h00},
    {1'b0,1'b1,3'd4,1'b1,8'h10},
    {1'b0,1'b1,3'd5,1'b1,8'h30},
    {1'b1,1'b0,3'd7,1'b1,8'h00},
    {1'b0,1'b1,3'd7,1'b1,8'h80},
    {1'b1,1'b1,3'd0,1'b0,8'h80},
    {1'b0,1'b1,3'd0,1'b1,8'h81}
  };

  function automatic string modeTag(input logic en, input logic cl);
    if (en && !cl)  return "R1 clear";
    if (!en && cl)  return "R2 write";
    if (en && cl)   return "R3 hold";
    return "R4 decode";
  endfunction

  task automatic check(input string tag, input logic [7:0] expV);
    applied++;
    if (cellsOut !== expV) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", tag, cellsOut, expV);
    end
  endtask

  // Drive at the falling edge, sample 2 ns after the rising edge
  task automatic step(input logic en, input logic cl, input logic [2:0] a,
                      input logic d);
    @(negedge clk);
    enableN = en; clearN = cl; addrIn = a; dataIn = d;
    @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (2) @(posedge clk);
    // Table walk: reset state first (R1), then all four modes
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][13], VEC[i][12], VEC[i][11:9], VEC[i][8]);
      check($sformatf("%s vec %0d", modeTag(VEC[i][13], VEC[i][12]), i),
            VEC[i][7:0]);
    end

    // R5: every address decodes to its own output bit
    for (int k = 0; k < 8; k++) begin
      step(1'b1, 1'b1, 3'(k), 1'b0);
      step(1'b0, 1'b0, 3'(k), 1'b1);
      check($sformatf("R5 decode addr %0d", k), 8'(1) << k);
    end

    // R6: decoded pattern survives the following hold cycles
    step(1'b0, 1'b0, 3'd6, 1'b1);
    step(1'b1, 1'b1, 3'd1, 1'b0);
    check("R6 hold after decode", 8'h40);
    step(1'b1, 1'b1, 3'd3, 1'b1);
    check("R6 second hold", 8'h40);

    // R7: a mid-cycle input change shows nothing until the next edge
    @(negedge clk);
    enableN = 1'b0; clearN = 1'b1; addrIn = 3'd3; dataIn = 1'b1;
    #1;
    check("R7 before edge", 8'h40);
    @(posedge clk);
    #2;
    check("R7 after edge", 8'h48);
    // R7: data flipped after the edge is not stored once hold returns
    @(negedge clk);
    enableN = 1'b1; dataIn = 1'b0;
    @(posedge clk);
    #2;
    check("R7 captured at edge", 8'h48);

    // R1: clear ignores address and data
    step(1'b1, 1'b0, 3'd3, 1'b1);
    check("R1 final clear", 8'h00);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end
endmodule